// File: doc/BRIEF.md
# Flash erase command sequence decoder

This block sits on the device side of a parallel NOR-style flash. It watches the write cycles the host places on the address and data bus. It looks for the six-write unlock handshake that must come before a block erase or a sector erase. A write is taken when the combined active-low strobe rises, which happens when the first of the write enable and chip enable pins goes high. Output enable must be high for the write to count. Address and data are sampled in the clock cycle where that rising edge is seen. All inputs are assumed to be synchronous to `clk`.

The first five writes must carry fixed address and data pairs. The sixth write carries the target address, and its data byte chooses the erase size. When the whole sequence matches, the block issues a one-cycle erase request. The request carries the erase type and the target address, aligned down to the start of its block or sector. A busy flag then stays high for a set number of clock cycles to model the erase time. Any write that breaks the sequence drops the decoder back to idle.

Top module: `flash_erase_seq`

## Requirements
- R1: Six accepted writes with low-byte data AAh, 55h, 80h, AAh, 55h, 50h, at addresses 5555h, 2AAAh, 5555h, 5555h, 2AAAh and then any target address, produce one erase request with `erase_is_block` = 1.
- R2: The same sequence with sixth-write data 30h produces one erase request with `erase_is_block` = 0, which means a sector erase.
- R3: A write is accepted on the rising edge of (`we_n` OR `ce_n`), so either pin may end the write. A write made while `oe_n` is low is not accepted.
- R4: Data bits 15..8 are ignored in every write of the sequence.
- R5: For the first five writes, only address bits 14..0 are compared, so bits above 14 are ignored.
- R6: An accepted write that does not match the pair expected at the current step returns the decoder to idle with no erase. The sequence must then restart from its first write. A sixth-write data byte other than 50h or 30h also returns the decoder to idle.
- R7: With each request, `erase_addr` equals the sixth-write address with its low BLOCK_W bits cleared for a block erase, or its low SECTOR_W bits cleared for a sector erase.
- R8: `erase_req` is high for exactly one cycle. `busy` rises in that same cycle and stays high for exactly ERASE_CYCLES cycles.
- R9: Writes accepted while `busy` is high have no effect on the sequence. After `busy` falls, the decoder is idle.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `erase_req` and `busy` are low and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Write enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; a write needs it high |
| addr | input | ADDR_W | Word address bus |
| data | input | 16 | Data bus; only the low byte is decoded |
| erase_req | output | 1 | One-cycle pulse when a full erase sequence is accepted |
| erase_is_block | output | 1 | 1 for a block erase, 0 for a sector erase |
| erase_addr | output | ADDR_W | Target address aligned to the erase unit |
| busy | output | 1 | High while the erase time runs |

## Verification
Some properties are checked by the assertions on every cycle. The request is a single-cycle pulse. It never arrives while the block is already busy. It always comes together with the rise of busy. Its address is aligned to the granularity it reports. Its capturing write had output enable high. Other behaviour can only be shown by the bench scenarios. These cover the exact address and data pairs, abort and restart after a mismatch, and ignoring the upper data byte and the upper address bits. They also cover both strobe orders, the full length of the busy window, and writes ignored while busy.

// File: rtl/flash_erase_pkg.sv
// Package: flash_erase_pkg
// Shared step encoding and the command constants used by the erase
// sequence decoder. The step value counts the writes already matched.
package flash_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GOT1  = 3'd1,
        ST_GOT2  = 3'd2,
        ST_GOT3  = 3'd3,
        ST_GOT4  = 3'd4,
        ST_GOT5  = 3'd5
    } seq_step_e;

    localparam int          KEY_AW      = 15;
    localparam logic [14:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [14:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [7:0]  KEY_D_FIRST = 8'hAA;
    localparam logic [7:0]  KEY_D_SECND = 8'h55;
    localparam logic [7:0]  KEY_D_SETUP = 8'h80;
    localparam logic [7:0]  CMD_BLOCK   = 8'h50;
    localparam logic [7:0]  CMD_SECTOR  = 8'h30;

endpackage

// File: rtl/fe_strobe_detect.sv
// Module: fe_strobe_detect
// Produces a one-cycle write pulse when the combined active-low strobe
// (we_n OR ce_n) goes from low to high while oe_n is high.
// Assumes the strobe pins are synchronous to clk.
module fe_strobe_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic wr_stb
);
    logic strobe_n;
    logic strobe_q;

    // Combine the two strobes: the write ends when either pin rises.
    assign strobe_n = we_n | ce_n;

    // Keep the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    // Rising edge qualified by output enable inactive.
    assign wr_stb = strobe_n & ~strobe_q & oe_n;
endmodule

// File: rtl/fe_seq_fsm.sv
// Module: fe_seq_fsm
// Follows the six-write erase handshake. It compares the low 15 address
// bits and the low data byte against the pair expected at each step.
// A mismatch returns the FSM to idle. The hit output is combinational and
// valid in the cycle of the sixth matching write.
// Assumes wr_stb is a single-cycle pulse.
module fe_seq_fsm
    import flash_erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              accept,
    input  logic [KEY_AW-1:0] addr_lo,
    input  logic [7:0]        data_lo,
    output logic              hit,
    output logic              hit_block
);
    seq_step_e         step_q;
    seq_step_e         step_nx;
    logic [KEY_AW-1:0] exp_addr;
    logic [7:0]        exp_data;
    logic              pair_ok;
    logic              is_blk;
    logic              is_sec;

    // Expected address and data for the write that the current step awaits.
    always_comb begin
        unique case (step_q)
            ST_IDLE: begin exp_addr = KEY_ADDR_HI; exp_data = KEY_D_FIRST; end
            ST_GOT1: begin exp_addr = KEY_ADDR_LO; exp_data = KEY_D_SECND; end
            ST_GOT2: begin exp_addr = KEY_ADDR_HI; exp_data = KEY_D_SETUP; end
            ST_GOT3: begin exp_addr = KEY_ADDR_HI; exp_data = KEY_D_FIRST; end
            ST_GOT4: begin exp_addr = KEY_ADDR_LO; exp_data = KEY_D_SECND; end
            default: begin exp_addr = '0;          exp_data = 8'h00;       end
        endcase
    end

    assign pair_ok = (addr_lo == exp_addr) && (data_lo == exp_data);
    assign is_blk  = (data_lo == CMD_BLOCK);
    assign is_sec  = (data_lo == CMD_SECTOR);

    // Next step: advance on a match; otherwise, and after the sixth write, go idle.
    always_comb begin
        step_nx = step_q;
        if (wr_stb && accept) begin
            unique case (step_q)
                ST_IDLE: step_nx = pair_ok ? ST_GOT1 : ST_IDLE;
                ST_GOT1: step_nx = pair_ok ? ST_GOT2 : ST_IDLE;
                ST_GOT2: step_nx = pair_ok ? ST_GOT3 : ST_IDLE;
                ST_GOT3: step_nx = pair_ok ? ST_GOT4 : ST_IDLE;
                ST_GOT4: step_nx = pair_ok ? ST_GOT5 : ST_IDLE;
                default: step_nx = ST_IDLE;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_nx;
    end

    // A full match means the sixth write carried a known erase code.
    assign hit       = wr_stb && accept && (step_q == ST_GOT5) && (is_blk || is_sec);
    assign hit_block = is_blk;
endmodule

// File: rtl/fe_busy_timer.sv
// Module: fe_busy_timer
// Holds busy high for exactly CYCLES clock cycles, starting in the cycle
// after start is seen. Assumes start is never raised while busy is high.
module fe_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain_q <= '0;
        else if (start)         remain_q <= CNT_W'(CYCLES);
        else if (remain_q != 0) remain_q <= remain_q - 1'b1;
    end

    assign busy = (remain_q != '0);
endmodule

// File: rtl/flash_erase_seq.sv
// Module: flash_erase_seq (top)
// Erase command sequence decoder. It finds the six-write unlock and erase
// handshake and issues a one-cycle erase request. The request carries the
// target address aligned to a block or sector. Busy then stays high for
// ERASE_CYCLES cycles.
// Assumes bus inputs are synchronous to clk and BLOCK_W >= SECTOR_W,
// BLOCK_W < ADDR_W, and ADDR_W >= 15.
module flash_erase_seq #(
    parameter int ADDR_W       = 18,
    parameter int SECTOR_W     = 11,
    parameter int BLOCK_W      = 15,
    parameter int ERASE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    output logic              erase_req,
    output logic              erase_is_block,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              busy
);
    import flash_erase_pkg::*;

    localparam logic [ADDR_W-1:0] ONES     = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BLK_MASK = ONES << BLOCK_W;
    localparam logic [ADDR_W-1:0] SEC_MASK = ONES << SECTOR_W;

    logic wr_stb;
    logic hit;
    logic hit_block;
    logic unused_hi;

    // The upper data byte plays no part in any command.
    assign unused_hi = ^data[15:8];

    fe_strobe_detect u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_n   (we_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .wr_stb (wr_stb)
    );

    fe_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .accept    (~busy),
        .addr_lo   (addr[KEY_AW-1:0]),
        .data_lo   (data[7:0]),
        .hit       (hit),
        .hit_block (hit_block)
    );

    fe_busy_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (hit),
        .busy  (busy)
    );

    // Register the request pulse, the erase type and the aligned target address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_req      <= 1'b0;
            erase_is_block <= 1'b0;
            erase_addr     <= '0;
        end else begin
            erase_req <= hit;
            if (hit) begin
                erase_is_block <= hit_block;
                erase_addr     <= addr & (hit_block ? BLK_MASK : SEC_MASK);
            end
        end
    end
endmodule

// File: rtl/flash_erase_seq_chk.sv
// Module: flash_erase_seq_chk
// Property checker bound to flash_erase_seq. It watches the request pulse,
// the busy window and the alignment of the reported address.
module flash_erase_seq_chk #(
    parameter int ADDR_W   = 18,
    parameter int SECTOR_W = 11,
    parameter int BLOCK_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              erase_req,
    input logic              erase_is_block,
    input logic [ADDR_W-1:0] erase_addr,
    input logic              busy
);
    // R8
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    // R8
    busy_starts_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> erase_req);

    // R9
    no_req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(busy));

    // R7
    block_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_is_block) |-> (erase_addr[BLOCK_W-1:0] == '0));

    // R7
    sector_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_is_block) |-> (erase_addr[SECTOR_W-1:0] == '0));

    // R3
    req_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(oe_n));

    // R10
    quiet_after_reset_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!erase_req && !busy));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
    .ADDR_W   (ADDR_W),
    .SECTOR_W (SECTOR_W),
    .BLOCK_W  (BLOCK_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .oe_n           (oe_n),
    .erase_req      (erase_req),
    .erase_is_block (erase_is_block),
    .erase_addr     (erase_addr),
    .busy           (busy)
);

// File: tb/flash_erase_seq_bench.sv
// Scoreboard bench for flash_erase_seq. The driver tasks push the expected
// requests into a queue, and a monitor pops and compares them at each request.
module flash_erase_seq_bench;
    localparam int ADDR_W   = 18;
    localparam int SECTOR_W = 11;
    localparam int BLOCK_W  = 15;
    localparam int ERASE_CY = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we_n = 1'b1;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       data = '0;
    logic              erase_req;
    logic              erase_is_block;
    logic [ADDR_W-1:0] erase_addr;
    logic              busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic              blk;
        logic [ADDR_W-1:0] a;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    flash_erase_seq #(
        .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W), .ERASE_CYCLES(ERASE_CY)
    ) u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .data(data), .erase_req(erase_req),
        .erase_is_block(erase_is_block), .erase_addr(erase_addr), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bus write; use_ce picks which pin rises first and ends the write.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                             input bit use_ce, input bit oe_low);
        @(negedge clk);
        addr = a; data = d; oe_n = ~oe_low;
        if (use_ce) we_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        if (use_ce) ce_n = 1'b0; else we_n = 1'b0;
        @(negedge clk);
        if (use_ce) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        if (use_ce) we_n = 1'b1; else ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    // Full six-write sequence; hi_a and hi_d fill the ignored upper bits.
    task automatic erase_seq(input logic [ADDR_W-1:0] tgt, input logic [7:0] code,
                             input bit use_ce, input logic [ADDR_W-1:0] hi_a,
                             input logic [7:0] hi_d, input bit expect_req);
        exp_t e;
        if (expect_req) begin
            e.blk = (code == 8'h50);
            e.a   = e.blk ? ((tgt >> BLOCK_W) << BLOCK_W) : ((tgt >> SECTOR_W) << SECTOR_W);
            exp_q.push_back(e);
        end
        bus_write(hi_a | 18'h05555, {hi_d, 8'hAA}, use_ce, 1'b0);
        bus_write(hi_a | 18'h02AAA, {hi_d, 8'h55}, use_ce, 1'b0);
        bus_write(hi_a | 18'h05555, {hi_d, 8'h80}, use_ce, 1'b0);
        bus_write(hi_a | 18'h05555, {hi_d, 8'hAA}, use_ce, 1'b0);
        bus_write(hi_a | 18'h02AAA, {hi_d, 8'h55}, use_ce, 1'b0);
        bus_write(tgt, {hi_d, code}, use_ce, 1'b0);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each request with the queue head and measure the busy length.
    int busy_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (erase_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected erase request", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(erase_is_block == e.blk, e.blk ? "R1" : "R2", "erase type",
                          erase_is_block, e.blk);
                    check(erase_addr == e.a, "R7", "aligned erase address", erase_addr, e.a);
                    check(busy == 1'b1, "R8", "busy with request", busy, 1);
                end
            end
            if (busy) busy_len++;
            else if (busy_len != 0) begin
                check(busy_len == ERASE_CY, "R8", "busy length", busy_len, ERASE_CY);
                busy_len = 0;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: state held in reset
        check(!erase_req && !busy, "R10", "outputs in reset", {erase_req, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!erase_req && !busy, "R10", "outputs after reset", {erase_req, busy}, 0);

        // R1: block erase, write-enable controlled
        erase_seq(18'h2D123, 8'h50, 1'b0, '0, 8'h00, 1'b1);
        wait_idle();
        // R2: sector erase, chip-enable controlled (R3)
        erase_seq(18'h1B7FF, 8'h30, 1'b1, '0, 8'h00, 1'b1);
        wait_idle();
        // R4 and R5: junk upper data byte and upper address bits
        erase_seq(18'h3C801, 8'h30, 1'b0, 18'h38000, 8'hC3, 1'b1);
        wait_idle();
        erase_seq(18'h0FFFF, 8'h50, 1'b1, 18'h18000, 8'hFF, 1'b1);
        wait_idle();

        // R6: wrong data in the third write, then the rest of the sequence
        bus_write(18'h05555, 16'h00AA, 1'b0, 1'b0);
        bus_write(18'h02AAA, 16'h0055, 1'b0, 1'b0);
        bus_write(18'h05555, 16'h0090, 1'b0, 1'b0);
        bus_write(18'h05555, 16'h00AA, 1'b0, 1'b0);
        bus_write(18'h02AAA, 16'h0055, 1'b0, 1'b0);
        bus_write(18'h12345, 16'h0050, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(!busy, "R6", "no erase after data mismatch", busy, 0);
        // R6: wrong address in the second write
        bus_write(18'h05555, 16'h00AA, 1'b1, 1'b0);
        bus_write(18'h02AAB, 16'h0055, 1'b1, 1'b0);
        bus_write(18'h05555, 16'h0080, 1'b1, 1'b0);
        bus_write(18'h05555, 16'h00AA, 1'b1, 1'b0);
        bus_write(18'h02AAA, 16'h0055, 1'b1, 1'b0);
        bus_write(18'h12345, 16'h0030, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check(!busy, "R6", "no erase after address mismatch", busy, 0);
        // R6: unknown erase code in the sixth write
        erase_seq(18'h22222, 8'h10, 1'b0, '0, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        check(!busy, "R6", "no erase on unknown code", busy, 0);

        // R3: sequence with oe_n low on every write is ignored
        bus_write(18'h05555, 16'h00AA, 1'b0, 1'b1);
        bus_write(18'h02AAA, 16'h0055, 1'b0, 1'b1);
        bus_write(18'h05555, 16'h0080, 1'b0, 1'b1);
        bus_write(18'h05555, 16'h00AA, 1'b0, 1'b1);
        bus_write(18'h02AAA, 16'h0055, 1'b0, 1'b1);
        bus_write(18'h11111, 16'h0050, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check(!busy, "R3", "writes with oe_n low ignored", busy, 0);

        // R9: full sequence issued while busy, then a lone sixth write
        erase_seq(18'h08000, 8'h50, 1'b0, '0, 8'h00, 1'b1);
        erase_seq(18'h30000, 8'h30, 1'b0, '0, 8'h00, 1'b0);
        check(busy, "R9", "still busy during second sequence", busy, 1);
        wait_idle();
        bus_write(18'h30000, 16'h0030, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(!busy, "R9", "decoder idle after busy", busy, 0);

        // R1: after all aborts a clean sequence still works
        erase_seq(18'h00000, 8'h50, 1'b1, '0, 8'h00, 1'b1);
        wait_idle();
        check(exp_q.size() == 0, "R1", "all expected requests seen", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule